// File: doc/BRIEF.md
# SD Card Command Line Engine

This block is the host side of the command path of an SD card link in four-bit bus mode. It divides the system clock down to a free-running card clock. On request it shifts a command frame out on the bidirectional CMD pin. When a reply is expected, it lets go of the pin, waits for the card to pull it low and gathers the reply into 32-bit words.

A command is handed over as two 32-bit words. The first word holds the transmit bit count minus one in bits 31..24, followed by the first 24 frame bits in bits 23..0. The second word holds the last 24 frame bits in bits 31..8 and the reply bit count minus one in bits 7..0. A zero reply field marks a command with no reply. The engine does not generate CRC and has no timeouts. The data lines are handled elsewhere.

Top module: `sdio_cmd_engine`

## Requirements
- R1: `sd_clk` toggles without pause, idle or busy, with a period of CLK_DIV system cycles. It stays low for (CLK_DIV+1)/2 cycles and high for CLK_DIV/2 cycles, which is 3 low and 2 high at the default.
- R2: `cmd_ready` is high only while the engine is idle, for one cycle per card clock period: the last high cycle before `sd_clk` falls. A command is taken in a cycle where `cmd_valid` and `cmd_ready` are both high, and `cmd_valid` means both words are present.
- R3: On acceptance `cmd_out` is set to 1 while `cmd_oe` stays 0. `cmd_oe` goes to 1 at the next rising `sd_clk` edge with `cmd_out` still 1, before any frame bit is driven.
- R4: The frame is word0[31:24]+1 bits (at most 48) long and taken MSB first from {word0[23:0], word1[31:8]}. `cmd_out` changes only in the cycle in which `sd_clk` falls.
- R5: One card clock period after the last frame bit, `cmd_oe` returns to 0 at a falling `sd_clk` edge. Each rising `sd_clk` edge with `cmd_oe` high shows exactly one bit: the preamble 1 first, then the frame bits.
- R6: With word1[7:0] = 0 no reply is collected, no `rsp_valid` is produced and `busy` drops at the release edge.
- R7: With a nonzero reply field L, `cmd_in` is sampled only at the system edge that drives `sd_clk` low. The first low sample after the release is the start bit. Exactly L+1 bits, including that start bit, are collected, however long the card waits before replying.
- R8: Reply bits are packed MSB first into 32-bit words, each shown as a one-cycle `rsp_valid` pulse. A final partial word holds its bits right-aligned with zeros above them.
- R9: `busy` is 1 from the cycle after acceptance and falls in the cycle the last reply word is presented, or at the release when there is no reply.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Both command words are present |
| cmd_word0 | input | 32 | Bit count field and leading 24 frame bits |
| cmd_word1 | input | 32 | Trailing 24 frame bits and reply length field |
| cmd_ready | output | 1 | Engine takes the command this cycle |
| busy | output | 1 | Command or reply in progress |
| rsp_valid | output | 1 | One-cycle strobe for `rsp_word` |
| rsp_word | output | 32 | Packed reply bits |
| sd_clk | output | 1 | Card clock |
| cmd_in | input | 1 | CMD pin as read back |
| cmd_out | output | 1 | CMD value driven when enabled |
| cmd_oe | output | 1 | CMD output enable |

## Verification
The bench acts as the card. It waits a random number of card clock periods before its start bit, which would expose an engine that samples on a fixed schedule after release, or on the wrong clock edge, because the reply words would come out shifted. Reply lengths of 32 and 33 bits hit the exact-fill and single-bit-overflow cases, where a packer that drops or pads the final word the wrong way shows a missing or misaligned word. Frames of 1 and 48 bits and a no-reply command check off-by-one bit counts and whether `busy` drops at release when no reply is expected.

// File: rtl/sdce_pkg.sv
package sdce_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_TX,
    ST_TURN,
    ST_WAIT,
    ST_RX
  } seq_state_t;
endpackage

// File: rtl/sdce_clkgen.sv
// Free-running card clock with a long low phase; event strobes mark the
// system cycles at whose end sd_clk falls or rises.
module sdce_clkgen #(
  parameter int CLK_DIV = 5
) (
  input  logic clk,
  input  logic rst,
  output logic sd_clk,
  output logic fall_evt,
  output logic rise_evt
);
  localparam int LOW_CYC = (CLK_DIV + 1) / 2;
  localparam int PH_W    = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam logic [PH_W-1:0] LAST_P = PH_W'(CLK_DIV - 1);
  localparam logic [PH_W-1:0] LOW_P  = PH_W'(LOW_CYC);
  localparam logic [PH_W-1:0] RISE_P = PH_W'(LOW_CYC - 1);

  logic [PH_W-1:0] ph;
  logic [PH_W-1:0] ph_next;

  always_comb begin
    ph_next = (ph == LAST_P) ? '0 : ph + 1'b1;
  end

  assign fall_evt = (ph == LAST_P);
  assign rise_evt = (ph == RISE_P);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= '0;
      sd_clk <= 1'b0;
    end else begin
      ph     <= ph_next;
      sd_clk <= (ph_next >= LOW_P);
    end
  end
endmodule

// File: rtl/sdce_rsp_packer.sv
// Collects reply bits MSB first; a partial last word stays right-aligned.
module sdce_rsp_packer #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              samp_en,
  input  logic              samp_bit,
  input  logic              samp_last,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_word
);
  localparam int FILL_W = $clog2(WORD_W);
  localparam logic [FILL_W-1:0] FULL = FILL_W'(WORD_W - 1);

  logic [WORD_W-1:0] acc;
  logic [WORD_W-1:0] acc_nxt;
  logic [FILL_W-1:0] fill;

  assign acc_nxt = {acc[WORD_W-2:0], samp_bit};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      fill      <= '0;
      rsp_valid <= 1'b0;
      rsp_word  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (clr) begin
        acc  <= '0;
        fill <= '0;
      end else if (samp_en) begin
        if (fill == FULL || samp_last) begin
          rsp_word  <= acc_nxt;
          rsp_valid <= 1'b1;
          acc       <= '0;
          fill      <= '0;
        end else begin
          acc  <= acc_nxt;
          fill <= fill + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sdce_sequencer.sv
// Command frame sequencing: preamble, serialization, release, start-bit hunt
// and reply bit counting. All pin actions ride on the clock strobes.
module sdce_sequencer
  import sdce_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fall_evt,
  input  logic              rise_evt,
  input  logic              cmd_valid,
  input  logic [WORD_W-1:0] cmd_word0,
  input  logic [WORD_W-1:0] cmd_word1,
  input  logic              cmd_in,
  output logic              cmd_ready,
  output logic              cmd_out,
  output logic              cmd_oe,
  output logic              busy,
  output logic              clr,
  output logic              samp_en,
  output logic              samp_bit,
  output logic              samp_last
);
  localparam int SEG_W = WORD_W - LEN_W;
  localparam int SH_W  = 2 * SEG_W;
  localparam logic [LEN_W:0] ONE_LEFT = (LEN_W + 1)'(1);

  seq_state_t       state;
  logic [SH_W-1:0]  sh;
  logic [LEN_W-1:0] txc;
  logic [LEN_W-1:0] rlen;
  logic [LEN_W:0]   rxc;
  logic             accept;

  assign cmd_ready = (state == ST_IDLE) && fall_evt;
  assign accept    = cmd_valid && cmd_ready;
  assign clr       = accept;
  assign samp_bit  = cmd_in;
  assign samp_en   = fall_evt && (((state == ST_WAIT) && !cmd_in) || (state == ST_RX));
  assign samp_last = (state == ST_RX) && (rxc == ONE_LEFT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      sh      <= '0;
      txc     <= '0;
      rlen    <= '0;
      rxc     <= '0;
      cmd_out <= 1'b1;
      cmd_oe  <= 1'b0;
      busy    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            sh      <= {cmd_word0[SEG_W-1:0], cmd_word1[WORD_W-1:LEN_W]};
            txc     <= cmd_word0[WORD_W-1:SEG_W];
            rlen    <= cmd_word1[LEN_W-1:0];
            cmd_out <= 1'b1;
            busy    <= 1'b1;
            state   <= ST_PRE;
          end
        end
        ST_PRE: begin
          if (rise_evt) begin
            cmd_oe <= 1'b1;
            state  <= ST_TX;
          end
        end
        ST_TX: begin
          if (fall_evt) begin
            cmd_out <= sh[SH_W-1];
            sh      <= {sh[SH_W-2:0], 1'b0};
            if (txc == '0) state <= ST_TURN;
            else           txc   <= txc - 1'b1;
          end
        end
        ST_TURN: begin
          if (fall_evt) begin
            cmd_oe  <= 1'b0;
            cmd_out <= 1'b1;
            if (rlen == '0) begin
              busy  <= 1'b0;
              state <= ST_IDLE;
            end else begin
              state <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (fall_evt && !cmd_in) begin
            rxc   <= {1'b0, rlen};
            state <= ST_RX;
          end
        end
        ST_RX: begin
          if (fall_evt) begin
            rxc <= rxc - 1'b1;
            if (rxc == ONE_LEFT) begin
              busy  <= 1'b0;
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdio_cmd_engine.sv
module sdio_cmd_engine #(
  parameter int CLK_DIV = 5,
  parameter int WORD_W  = 32,
  parameter int LEN_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [WORD_W-1:0] cmd_word0,
  input  logic [WORD_W-1:0] cmd_word1,
  output logic              cmd_ready,
  output logic              busy,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_word,
  output logic              sd_clk,
  input  logic              cmd_in,
  output logic              cmd_out,
  output logic              cmd_oe
);
  logic fall_evt;
  logic rise_evt;
  logic clr;
  logic samp_en;
  logic samp_bit;
  logic samp_last;

  sdce_clkgen #(.CLK_DIV(CLK_DIV)) u_clkgen (
    .clk      (clk),
    .rst      (rst),
    .sd_clk   (sd_clk),
    .fall_evt (fall_evt),
    .rise_evt (rise_evt)
  );

  sdce_sequencer #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .fall_evt  (fall_evt),
    .rise_evt  (rise_evt),
    .cmd_valid (cmd_valid),
    .cmd_word0 (cmd_word0),
    .cmd_word1 (cmd_word1),
    .cmd_in    (cmd_in),
    .cmd_ready (cmd_ready),
    .cmd_out   (cmd_out),
    .cmd_oe    (cmd_oe),
    .busy      (busy),
    .clr       (clr),
    .samp_en   (samp_en),
    .samp_bit  (samp_bit),
    .samp_last (samp_last)
  );

  sdce_rsp_packer #(.WORD_W(WORD_W)) u_pack (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .samp_en   (samp_en),
    .samp_bit  (samp_bit),
    .samp_last (samp_last),
    .rsp_valid (rsp_valid),
    .rsp_word  (rsp_word)
  );
endmodule

// File: rtl/sdio_cmd_engine_chk.sv
module sdio_cmd_engine_chk #(
  parameter int CLK_DIV = 5
) (
  input logic clk,
  input logic rst,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic busy,
  input logic rsp_valid,
  input logic sd_clk,
  input logic cmd_out,
  input logic cmd_oe
);
  localparam int LO_CYC = (CLK_DIV + 1) / 2;
  localparam int HI_CYC = CLK_DIV / 2;

  logic       prev_clk;
  logic       armed;
  logic [7:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_clk <= 1'b0;
      armed    <= 1'b0;
      run      <= '0;
    end else begin
      prev_clk <= sd_clk;
      if (sd_clk != prev_clk) begin
        run   <= 8'd1;
        armed <= 1'b1;
      end else if (run != 8'hff) begin
        run <= run + 8'd1;
      end
    end
  end

  assert_sdclk_shape_R1: assert property (@(posedge clk) disable iff (rst)
    (armed && (sd_clk != prev_clk)) |-> (run == (prev_clk ? 8'(HI_CYC) : 8'(LO_CYC))));

  assert_ready_idle_R2: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> !busy);

  assert_accept_busy_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> busy);

  assert_preamble_high_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_oe) |-> (cmd_out && $rose(sd_clk)));

  assert_edge_align_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_oe && $past(cmd_oe) && (cmd_out != $past(cmd_out))) |-> $fell(sd_clk));

  assert_release_fall_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(cmd_oe) |-> $fell(sd_clk));

  assert_idle_released_R6: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !cmd_oe);

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
endmodule

bind sdio_cmd_engine sdio_cmd_engine_chk #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .busy      (busy),
  .rsp_valid (rsp_valid),
  .sd_clk    (sd_clk),
  .cmd_out   (cmd_out),
  .cmd_oe    (cmd_oe)
);

// File: tb/sim_sdio_cmd_engine.sv
module sim_sdio_cmd_engine;
  localparam int CLK_P   = 10;
  localparam int CLK_DIV = 5;
  localparam int LO_EXP  = (CLK_DIV + 1) / 2;
  localparam int HI_EXP  = CLK_DIV / 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [31:0] cmd_word0 = '0;
  logic [31:0] cmd_word1 = '0;
  logic        cmd_ready, busy, rsp_valid, sd_clk, cmd_out, cmd_oe;
  logic [31:0] rsp_word;
  logic        cmd_in = 1'b1;

  int errors = 0;
  int checks = 0;
  logic        rb  [0:255];
  logic        cap [0:63];
  logic [31:0] got [0:15];
  int ncap;
  int nw;

  always #(CLK_P/2) clk = ~clk;

  sdio_cmd_engine #(.CLK_DIV(CLK_DIV)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word0(cmd_word0),
    .cmd_word1(cmd_word1), .cmd_ready(cmd_ready), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_word(rsp_word), .sd_clk(sd_clk),
    .cmd_in(cmd_in), .cmd_out(cmd_out), .cmd_oe(cmd_oe)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input int k, input int total);
    logic [31:0] w = '0;
    for (int i = 32 * k; i < 32 * k + 32 && i < total; i++) w = {w[30:0], rb[i]};
    return w;
  endfunction

  task automatic clk_shape();
    int lo = 0;
    int hi = 0;
    @(negedge clk);
    while (sd_clk !== 1'b1) @(negedge clk);
    while (sd_clk !== 1'b0) @(negedge clk);
    while (sd_clk === 1'b0) begin lo++; @(negedge clk); end
    while (sd_clk === 1'b1) begin hi++; @(negedge clk); end
    chk(lo == LO_EXP, "R1", "sd_clk low cycles", lo, LO_EXP);
    chk(hi == HI_EXP, "R1", "sd_clk high cycles", hi, HI_EXP);
  endtask

  task automatic run_cmd(input logic [7:0] nf, input logic [47:0] payload,
                         input logic [7:0] lf, input int dly);
    logic [31:0] w0 = {nf, payload[47:24]};
    logic [31:0] w1 = {payload[23:0], lf};
    int total = (lf == 0) ? 0 : int'(lf) + 1;
    int nexp  = (total + 31) / 32;
    int bad   = 0;
    rb[0] = 1'b0;
    for (int i = 1; i <= int'(lf); i++) rb[i] = 1'($urandom % 2);
    ncap = 0;
    nw   = 0;
    fork
      begin
        @(negedge clk);
        cmd_valid = 1'b1; cmd_word0 = w0; cmd_word1 = w1;
        while (cmd_ready !== 1'b1) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy === 1'b1, "R9", "busy after accept", busy, 1);
        chk(cmd_ready === 1'b0, "R2", "ready while busy", cmd_ready, 0);
        while (1) begin
          if (rsp_valid === 1'b1 && nw < 16) begin got[nw] = rsp_word; nw++; end
          if (busy === 1'b0) break;
          @(negedge clk);
        end
      end
      begin
        wait (cmd_oe === 1'b1);
        #1;
        cap[ncap] = cmd_out; ncap++;
        while (1) begin
          @(posedge sd_clk);
          #1;
          if (cmd_oe !== 1'b1) break;
          if (ncap < 64) begin cap[ncap] = cmd_out; ncap++; end
        end
      end
      begin
        if (lf != 0) begin
          wait (cmd_oe === 1'b1);
          wait (cmd_oe === 1'b0);
          #1;
          repeat (dly) begin @(negedge sd_clk); #1; end
          for (int i = 0; i <= int'(lf); i++) begin
            cmd_in = rb[i];
            @(negedge sd_clk);
            #1;
          end
          cmd_in = 1'b1;
        end
      end
    join
    chk(ncap == int'(nf) + 2, "R5", "bits shown while enabled", ncap, int'(nf) + 2);
    chk(cap[0] === 1'b1, "R3", "preamble level", cap[0], 1);
    for (int j = 0; j <= int'(nf) && j + 1 < ncap; j++)
      if (cap[j + 1] !== payload[47 - j]) bad++;
    chk(bad == 0, "R4", "frame bit mismatches", bad, 0);
    if (lf == 0) begin
      chk(nw == 0, "R6", "reply words without reply", nw, 0);
      chk(cmd_oe === 1'b0, "R6", "pin released", cmd_oe, 0);
    end else begin
      chk(nw == nexp, "R7", "reply word count", nw, nexp);
      for (int k = 0; k < nw && k < nexp; k++)
        chk(got[k] === exp_word(k, total), "R8", "reply word", got[k], exp_word(k, total));
    end
    repeat (1 + $urandom % 7) @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0, "R9", "reset busy", busy, 0);
    chk(cmd_oe === 1'b0, "R3", "reset enable", cmd_oe, 0);
    chk(cmd_out === 1'b1, "R3", "reset level", cmd_out, 1);
    chk(rsp_valid === 1'b0, "R8", "reset strobe", rsp_valid, 0);
    clk_shape();
    clk_shape();
    // directed corners
    run_cmd(8'd47, 48'h40_1234_5678_95, 8'd0, 0);
    run_cmd(8'd0, 48'h8000_0000_0000, 8'd31, 0);
    run_cmd(8'd47, 48'hA5C3_0F1E_2D3C, 8'd32, 3);
    run_cmd(8'd15, 48'hFFFF_0000_FFFF, 8'd135, 1);
    run_cmd(8'd47, 48'h4D00_0000_0001, 8'd47, 5);
    clk_shape();
    for (int n = 0; n < 12; n++) begin
      logic [7:0]  nf = 8'($urandom % 48);
      logic [47:0] pl = {16'($urandom), 32'($urandom)};
      logic [7:0]  lf = ($urandom % 4 == 0) ? 8'd0 : 8'($urandom % 136);
      run_cmd(nf, pl, lf, int'($urandom % 6));
    end
    clk_shape();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule